// File: doc/BRIEF.md
# Ping-pong DMA channel address engine

This block is the address and count engine of a single DMA channel that owns two buffer descriptors, A and B, and runs them alternately. Each descriptor holds a source address, a destination address and a count of remaining transfer cycles. Firmware programs a descriptor through a simple register write port, writing the count last. Writing a non-zero count arms that buffer. The channel also has a control register that selects peripheral mode, direction and transfer size.

While a buffer is running, the engine raises a transfer request and presents the read and write addresses for the current transfer cycle. A bus-side agent answers with a done strobe. On every completed cycle the engine decrements the active count and moves each address forward by the transfer size, unless peripheral mode holds that address on a fixed port. When the active count reaches zero, the engine pulses that buffer's completion flag. It then either moves straight to the other buffer, if that buffer is armed, or goes idle. This lets firmware refill one buffer while the other drains.

Top module: `ppdma_channel`

## Requirements
- R1: After reset every descriptor field and the control register read as zero, and `xfer_req`, `busy`, `done_a` and `done_b` are low.
- R2: Register offsets are 0x00/0x04/0x08 for the A source, destination and count, 0x0C/0x10/0x14 for the B source, destination and count, and 0x18 for control. A count reads back in bits [15:0] with bits [31:16] zero. Control bit 0 is peripheral mode, bit 1 is direction, bits [3:2] are transfer size, and control bits [31:4] read as zero.
- R3: A buffer whose count is non-zero is armed. Writing zero to a count does not start the channel. An idle channel starts on the first cycle with a non-zero count and no register write in progress. If both buffers are armed at that point, buffer A starts first.
- R4: While running, `xfer_req` is high, `active_buf` names the running buffer (0 = A, 1 = B), and `rd_addr`/`wr_addr` equal that buffer's current source and destination.
- R5: A cycle with `xfer_req` and `xfer_done` both high completes one transfer, and the active count drops by exactly one.
- R6: Transfer size code 0 steps addresses by 1, code 1 by 2, and codes 2 and 3 by 4. Address arithmetic wraps modulo 2^32.
- R7: The source address stays fixed across completed transfers when peripheral mode is 1 and direction is 0. Otherwise it advances by the step.
- R8: The destination address stays fixed across completed transfers when peripheral mode is 1 and direction is 1. Otherwise it advances by the step.
- R9: The transfer that brings a count to zero produces a single-cycle pulse on that buffer's done output in the following cycle. The two done outputs are never high together.
- R10: When the active buffer finishes and the other buffer is armed, the next cycle requests on the other buffer. Otherwise the channel goes idle.
- R11: Writes to the descriptor of the buffer that is not running leave the running buffer's addresses, count and request sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 5 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 5 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| xfer_req | output | 1 | Transfer cycle request |
| xfer_done | input | 1 | Transfer cycle completion from the bus side |
| rd_addr | output | 32 | Read address of the current transfer cycle |
| wr_addr | output | 32 | Write address of the current transfer cycle |
| busy | output | 1 | Channel is running a buffer |
| active_buf | output | 1 | Running buffer, 0 = A, 1 = B |
| done_a | output | 1 | Buffer A completion pulse |
| done_b | output | 1 | Buffer B completion pulse |

## Verification
Two kinds of internal error show up at the ports in the very next cycle. A wrong step or hold decision shows as a wrong `rd_addr` or `wr_addr` on the next request. A bad decrement shows as a mismatch in the count read back before each completed transfer. Errors in the sequencer take longer to appear: they surface at the end of a buffer, one cycle after its final transfer, as a missing or misplaced done pulse, a request on the wrong buffer, or a channel that stays busy. The bench therefore follows every transfer of every buffer to its end, and it checks the cycle after each hand-over as closely as the transfers themselves.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } xfer_size_e;

   // control layout: bit0 peripheral, bit1 direction, bits3:2 size
   typedef struct packed {
      xfer_size_e size;
      logic       dir;
      logic       periph;
   } chan_ctrl_t;

   localparam int unsigned CTRL_W = $bits(chan_ctrl_t);

   function automatic logic [2:0] size_to_bytes(xfer_size_e s);
      logic [2:0] r;
      case (s)
         SZ_BYTE: r = 3'd1;
         SZ_HALF: r = 3'd2;
         default: r = 3'd4;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ppdma_step.sv
module ppdma_step
   import ppdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
)(
   input  chan_ctrl_t        ctrl,
   output logic [ADDR_W-1:0] src_inc,
   output logic [ADDR_W-1:0] dst_inc
);

   localparam int unsigned UNIT_W = 3;

   if (ADDR_W < UNIT_W) begin : g_bad_width
      $error("ppdma_step: ADDR_W too narrow for a word step");
   end

   logic [ADDR_W-1:0] unit;
   logic              hold_src;
   logic              hold_dst;

   always_comb begin
      unit     = '0;
      unit[UNIT_W-1:0] = size_to_bytes(ctrl.size);
      hold_src = ctrl.periph && !ctrl.dir;
      hold_dst = ctrl.periph &&  ctrl.dir;
      src_inc  = hold_src ? '0 : unit;
      dst_inc  = hold_dst ? '0 : unit;
   end

endmodule

// File: rtl/ppdma_desc.sv
module ppdma_desc #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_src,
   input  logic              wr_dst,
   input  logic              wr_cnt,
   input  logic [DATA_W-1:0] wdata,
   input  logic              adv,
   input  logic [ADDR_W-1:0] src_inc,
   input  logic [ADDR_W-1:0] dst_inc,
   output logic [ADDR_W-1:0] src_q,
   output logic [ADDR_W-1:0] dst_q,
   output logic [CNT_W-1:0]  cnt_q
);

   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("ppdma_desc: ADDR_W must not exceed DATA_W");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("ppdma_desc: CNT_W must not exceed DATA_W");
   end

   // a register write takes precedence over an advance on the same field
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= '0;
         dst_q <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_src)      src_q <= wdata[ADDR_W-1:0];
         else if (adv)    src_q <= src_q + src_inc;

         if (wr_dst)      dst_q <= wdata[ADDR_W-1:0];
         else if (adv)    dst_q <= dst_q + dst_inc;

         if (wr_cnt)      cnt_q <= wdata[CNT_W-1:0];
         else if (adv)    cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/ppdma_seq.sv
module ppdma_seq #(
   parameter int unsigned NB = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] armed,
   input  logic          last_act,
   input  logic          wr_busy,
   input  logic          xfer_done,
   output logic          run_q,
   output logic          act_q,
   output logic          req,
   output logic [NB-1:0] adv,
   output logic [NB-1:0] done_q
);

   if (NB != 2) begin : g_bad_nb
      $error("ppdma_seq: ping-pong sequencing needs exactly two buffers");
   end

   logic fire;
   logic other;
   logic leave;

   always_comb begin
      req   = run_q && armed[act_q];
      fire  = req && xfer_done;
      other = ~act_q;
      leave = (fire && last_act) || !armed[act_q];
      adv   = '0;
      adv[act_q] = fire;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         act_q  <= 1'b0;
         done_q <= '0;
      end else begin
         done_q <= '0;
         if (!run_q) begin
            if (!wr_busy && armed[0]) begin
               run_q <= 1'b1;
               act_q <= 1'b0;
            end else if (!wr_busy && armed[1]) begin
               run_q <= 1'b1;
               act_q <= 1'b1;
            end
         end else if (leave) begin
            if (fire) done_q[act_q] <= 1'b1;
            if (armed[other]) act_q <= other;
            else              run_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ppdma_channel.sv
module ppdma_channel
   import ppdma_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_AW = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_wr_addr,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic [REG_AW-1:0] reg_rd_addr,
   output logic [DATA_W-1:0] reg_rd_data,
   output logic              xfer_req,
   input  logic              xfer_done,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              busy,
   output logic              active_buf,
   output logic              done_a,
   output logic              done_b
);

   localparam int unsigned NB          = 2;
   localparam int unsigned FIELD_STEP  = 4;
   localparam int unsigned DESC_STRIDE = 3 * FIELD_STEP;
   localparam int unsigned OFS_CTRL    = NB * DESC_STRIDE;

   if (REG_AW < $clog2(OFS_CTRL + 1)) begin : g_bad_aw
      $error("ppdma_channel: REG_AW cannot reach the control register");
   end
   if (ADDR_W > DATA_W || CNT_W > DATA_W) begin : g_bad_dw
      $error("ppdma_channel: fields wider than the register data path");
   end
   if (CTRL_W > DATA_W) begin : g_bad_cw
      $error("ppdma_channel: control field wider than data path");
   end

   chan_ctrl_t        ctrl_q;
   logic [ADDR_W-1:0] src_inc;
   logic [ADDR_W-1:0] dst_inc;
   logic [ADDR_W-1:0] src_q [NB];
   logic [ADDR_W-1:0] dst_q [NB];
   logic [CNT_W-1:0]  cnt_q [NB];
   logic [NB-1:0]     armed;
   logic [NB-1:0]     adv;
   logic [NB-1:0]     done_q;
   logic              run_q;
   logic              act_q;
   logic              req;
   logic              last_act;
   logic              wr_ctrl;

   // control register
   assign wr_ctrl = reg_wr_en && (reg_wr_addr == REG_AW'(OFS_CTRL));

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= chan_ctrl_t'(reg_wr_data[CTRL_W-1:0]);
   end

   ppdma_step #(.ADDR_W(ADDR_W)) u_step (
      .ctrl    (ctrl_q),
      .src_inc (src_inc),
      .dst_inc (dst_inc)
   );

   // one descriptor per buffer
   for (genvar b = 0; b < NB; b++) begin : g_desc
      localparam int unsigned BASE = b * DESC_STRIDE;
      logic sel_src, sel_dst, sel_cnt;

      assign sel_src = reg_wr_en && (reg_wr_addr == REG_AW'(BASE));
      assign sel_dst = reg_wr_en && (reg_wr_addr == REG_AW'(BASE + FIELD_STEP));
      assign sel_cnt = reg_wr_en && (reg_wr_addr == REG_AW'(BASE + 2*FIELD_STEP));

      ppdma_desc #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W)
      ) u_desc (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_src  (sel_src),
         .wr_dst  (sel_dst),
         .wr_cnt  (sel_cnt),
         .wdata   (reg_wr_data),
         .adv     (adv[b]),
         .src_inc (src_inc),
         .dst_inc (dst_inc),
         .src_q   (src_q[b]),
         .dst_q   (dst_q[b]),
         .cnt_q   (cnt_q[b])
      );

      assign armed[b] = |cnt_q[b];
   end

   assign last_act = (cnt_q[act_q] == CNT_W'(1));

   ppdma_seq #(.NB(NB)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .last_act  (last_act),
      .wr_busy   (reg_wr_en),
      .xfer_done (xfer_done),
      .run_q     (run_q),
      .act_q     (act_q),
      .req       (req),
      .adv       (adv),
      .done_q    (done_q)
   );

   // register read-back
   always_comb begin
      reg_rd_data = '0;
      for (int b = 0; b < NB; b++) begin
         if (reg_rd_addr == REG_AW'(b * DESC_STRIDE))
            reg_rd_data[ADDR_W-1:0] = src_q[b];
         if (reg_rd_addr == REG_AW'(b * DESC_STRIDE + FIELD_STEP))
            reg_rd_data[ADDR_W-1:0] = dst_q[b];
         if (reg_rd_addr == REG_AW'(b * DESC_STRIDE + 2*FIELD_STEP))
            reg_rd_data[CNT_W-1:0] = cnt_q[b];
      end
      if (reg_rd_addr == REG_AW'(OFS_CTRL))
         reg_rd_data[CTRL_W-1:0] = ctrl_q;
   end

   assign xfer_req   = req;
   assign rd_addr    = src_q[act_q];
   assign wr_addr    = dst_q[act_q];
   assign busy       = run_q;
   assign active_buf = act_q;
   assign done_a     = done_q[0];
   assign done_b     = done_q[1];

endmodule

// File: rtl/ppdma_channel_chk.sv
module ppdma_channel_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned REG_AW = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [REG_AW-1:0] reg_wr_addr,
   input logic              xfer_req,
   input logic              xfer_done,
   input logic              busy,
   input logic              active_buf,
   input logic              done_a,
   input logic              done_b,
   input logic              periph,
   input logic              dir,
   input logic [ADDR_W-1:0] src_a,
   input logic [ADDR_W-1:0] dst_a,
   input logic [CNT_W-1:0]  cnt_a,
   input logic [ADDR_W-1:0] src_b,
   input logic [ADDR_W-1:0] dst_b,
   input logic [CNT_W-1:0]  cnt_b
);

   logic wr_src_a, wr_cnt_a, wr_dst_b, wr_cnt_b, wr_any_b;

   assign wr_src_a = reg_wr_en && (reg_wr_addr == REG_AW'(0));
   assign wr_cnt_a = reg_wr_en && (reg_wr_addr == REG_AW'(8));
   assign wr_dst_b = reg_wr_en && (reg_wr_addr == REG_AW'(16));
   assign wr_cnt_b = reg_wr_en && (reg_wr_addr == REG_AW'(20));
   assign wr_any_b = reg_wr_en && ((reg_wr_addr == REG_AW'(12)) ||
                                   (reg_wr_addr == REG_AW'(16)) ||
                                   (reg_wr_addr == REG_AW'(20)));

   assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cnt_a != '0 && !reg_wr_en) |=> (busy && active_buf == 1'b0));

   assert_req_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> busy);

   assert_cnt_dec_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_done && active_buf == 1'b0 && !wr_cnt_a)
      |=> cnt_a == $past(cnt_a) - 1'b1);

   assert_cnt_dec_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_done && active_buf == 1'b1 && !wr_cnt_b)
      |=> cnt_b == $past(cnt_b) - 1'b1);

   assert_src_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_done && active_buf == 1'b0 && periph && !dir && !wr_src_a)
      |=> src_a == $past(src_a));

   assert_dst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_done && active_buf == 1'b1 && periph && dir && !wr_dst_b)
      |=> dst_b == $past(dst_b));

   assert_done_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_a, done_b}));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_a |=> !done_a);

   assert_done_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_a |-> (cnt_a == '0 || $past(reg_wr_en)));

   assert_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_done && active_buf == 1'b0 && cnt_a == CNT_W'(1) &&
       !wr_cnt_a && cnt_b != '0 && !wr_cnt_b)
      |=> (busy && active_buf == 1'b1 && done_a));

   assert_inactive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && active_buf == 1'b0 && !wr_any_b)
      |=> ($stable(src_b) && $stable(dst_b) && $stable(cnt_b)));

endmodule

bind ppdma_channel ppdma_channel_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .REG_AW (REG_AW)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_addr (reg_wr_addr),
   .xfer_req    (xfer_req),
   .xfer_done   (xfer_done),
   .busy        (busy),
   .active_buf  (active_buf),
   .done_a      (done_a),
   .done_b      (done_b),
   .periph      (ctrl_q.periph),
   .dir         (ctrl_q.dir),
   .src_a       (src_q[0]),
   .dst_a       (dst_q[0]),
   .cnt_a       (cnt_q[0]),
   .src_b       (src_q[1]),
   .dst_b       (dst_q[1]),
   .cnt_b       (cnt_q[1])
);

// File: tb/ppdma_channel_tb.sv
module ppdma_channel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr_en;
   logic [4:0]  reg_wr_addr;
   logic [31:0] reg_wr_data;
   logic [4:0]  reg_rd_addr;
   logic [31:0] reg_rd_data;
   logic        xfer_req;
   logic        xfer_done;
   logic [31:0] rd_addr;
   logic [31:0] wr_addr;
   logic        busy;
   logic        active_buf;
   logic        done_a;
   logic        done_b;

   int n_vec  = 0;
   int n_fail = 0;

   // bench model of the programmed state
   logic [31:0] m_src [2];
   logic [31:0] m_dst [2];
   int          m_cnt [2];
   logic        m_pm, m_dir;
   logic [1:0]  m_sz;

   always #10 clk = ~clk;

   ppdma_channel dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_addr (reg_wr_addr),
      .reg_wr_data (reg_wr_data),
      .reg_rd_addr (reg_rd_addr),
      .reg_rd_data (reg_rd_data),
      .xfer_req    (xfer_req),
      .xfer_done   (xfer_done),
      .rd_addr     (rd_addr),
      .wr_addr     (wr_addr),
      .busy        (busy),
      .active_buf  (active_buf),
      .done_a      (done_a),
      .done_b      (done_b)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] step_of(input logic [1:0] s);
      return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
   endfunction

   task automatic model_write(input logic [4:0] a, input logic [31:0] d);
      case (a)
         5'h00: m_src[0] = d;
         5'h04: m_dst[0] = d;
         5'h08: m_cnt[0] = int'(d[15:0]);
         5'h0C: m_src[1] = d;
         5'h10: m_dst[1] = d;
         5'h14: m_cnt[1] = int'(d[15:0]);
         5'h18: begin m_pm = d[0]; m_dir = d[1]; m_sz = d[3:2]; end
         default: ;
      endcase
   endtask

   // one register write; called and returns on a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_wr_en   = 1'b1;
      reg_wr_addr = a;
      reg_wr_data = d;
      model_write(a, d);
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
      reg_rd_addr = a;
      #1;
      check(tag, reg_rd_data, exp);
   endtask

   // serve transfer requests until both buffers are drained
   task automatic service(input int inj_step, input logic [4:0] inj_a, input logic [31:0] inj_d);
      int cur   = -1;
      int pend  = -1;
      int fires = 0;
      check("R3 not started during programming", {31'd0, busy}, 32'd0);
      @(negedge clk);
      while (m_cnt[0] != 0 || m_cnt[1] != 0 || pend != -1) begin
         check("R9 done_a pulse", {31'd0, done_a}, {31'd0, pend == 0});
         check("R9 done_b pulse", {31'd0, done_b}, {31'd0, pend == 1});
         pend = -1;
         if (m_cnt[0] == 0 && m_cnt[1] == 0) begin
            check("R10 idle after last buffer", {30'd0, busy, xfer_req}, 32'd0);
         end else begin
            if (cur == -1) cur = (m_cnt[0] != 0) ? 0 : 1;
            check("R4 request", {31'd0, xfer_req}, 32'd1);
            check("R3/R10 active buffer", {31'd0, active_buf}, cur);
            check("R4/R7 read address", rd_addr, m_src[cur]);
            check("R4/R8 write address", wr_addr, m_dst[cur]);
            rd_check("R5 remaining count", (cur == 0) ? 5'h08 : 5'h14, m_cnt[cur]);
            xfer_done = 1'b1;
            if (fires == inj_step) begin
               reg_wr_en   = 1'b1;
               reg_wr_addr = inj_a;
               reg_wr_data = inj_d;
               model_write(inj_a, inj_d);
            end
            fires++;
            m_cnt[cur]--;
            if (!(m_pm && !m_dir)) m_src[cur] += step_of(m_sz);
            if (!(m_pm &&  m_dir)) m_dst[cur] += step_of(m_sz);
            if (m_cnt[cur] == 0) begin
               pend = cur;
               cur  = (m_cnt[1-cur] != 0) ? 1 - cur : -1;
            end
         end
         @(negedge clk);
         xfer_done = 1'b0;
         reg_wr_en = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1-R11 run actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      reg_wr_en   = 1'b0;
      reg_wr_addr = '0;
      reg_wr_data = '0;
      reg_rd_addr = '0;
      xfer_done   = 1'b0;
      for (int i = 0; i < 2; i++) begin m_src[i] = '0; m_dst[i] = '0; m_cnt[i] = 0; end
      m_pm = 1'b0; m_dir = 1'b0; m_sz = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a <= 24; a += 4) rd_check("R1 register reset value", 5'(a), 32'd0);
      check("R1 outputs after reset", {28'd0, xfer_req, busy, done_a, done_b}, 32'd0);

      // R2: map and reserved bits, R3: zero count does not arm
      wr(5'h0C, 32'h1234_5678);
      wr(5'h10, 32'h9ABC_DEF0);
      wr(5'h14, 32'hABCD_0000);
      wr(5'h18, 32'hFFFF_FFFF);
      @(negedge clk);
      rd_check("R2 B source", 5'h0C, 32'h1234_5678);
      rd_check("R2 B destination", 5'h10, 32'h9ABC_DEF0);
      rd_check("R2 count reserved bits", 5'h14, 32'd0);
      rd_check("R2 control reserved bits", 5'h18, 32'h0000_000F);
      rd_check("R2 A count untouched", 5'h08, 32'd0);
      check("R3 zero count leaves channel idle", {31'd0, busy}, 32'd0);

      // R6/R7/R8: sweep every control combination
      for (int cfg = 0; cfg < 16; cfg++) begin
         int b = cfg[1] ^ cfg[3];
         wr(5'h18, 32'(cfg));
         wr(5'(b * 12),     (cfg == 15) ? 32'hFFFF_FFFE : 32'h1000_0000 + 32'(cfg * 256));
         wr(5'(b * 12 + 4), 32'h2000_0000 - 32'(cfg * 64));
         wr(5'(b * 12 + 8), 32'hFFFF_0000 | 32'(2 + cfg % 3));
         service(-1, 5'h00, 32'd0);
      end

      // R3 priority and R10 hand-over: B armed before A, same write burst
      wr(5'h18, 32'h0000_0004);
      wr(5'h00, 32'h0000_4000);
      wr(5'h04, 32'h0000_5000);
      wr(5'h0C, 32'h0000_6000);
      wr(5'h10, 32'h0000_7000);
      wr(5'h14, 32'd2);
      wr(5'h08, 32'd3);
      service(-1, 5'h00, 32'd0);

      // R11: B running, A programmed and armed mid-run, then A runs
      wr(5'h18, 32'h0000_0005);
      wr(5'h00, 32'h0000_8000);
      wr(5'h04, 32'h0000_9000);
      wr(5'h0C, 32'h0000_A000);
      wr(5'h10, 32'h0000_B000);
      wr(5'h14, 32'd5);
      service(1, 5'h08, 32'd2);

      // R11: rewrite A source while B running (count still zero)
      wr(5'h18, 32'h0000_0002);
      wr(5'h14, 32'd4);
      service(2, 5'h00, 32'h0000_C000);
      rd_check("R11 A source took the write", 5'h00, 32'h0000_C000);
      rd_check("R11 A count stays zero", 5'h08, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule